// File: doc/BRIEF.md
# Endpoint Buffer-Empty / Size-Over Interrupt Status Register

This block keeps one sticky interrupt flag for each of seven endpoints of a USB device controller. What a flag reports depends on the endpoint's direction. An endpoint that receives data (OUT, or control-write on endpoint 0) flags a packet that is longer than its configured maximum packet size. An endpoint that sends data (IN, or control-read on endpoint 0) flags the case where the serial-engine side of its buffer has been fully sent while the CPU side holds nothing new.

When a size-over event occurs, the block also emits a one-cycle STALL request for that endpoint. This request does not depend on the endpoint's current handshake setting. Isochronous endpoints never raise a flag.

Software reads the flags through a 16-bit register at offset 0x1E. It clears a flag by writing 0 to that flag's bit. Endpoint 0 has two further hardware clear paths, both driven by its FIFO control logic. The flags are combined with an external enable vector into a single interrupt line.

Top module: `ep_irq_status_reg`

## Requirements
- R1: A hardware reset (`rst` high at a clock edge) sets all flags to 0 and deasserts all STALL requests.
- R2: A software reset (`sw_rst` high at a clock edge) also sets all flags to 0. A USB bus reset has no path into the block.
- R3: When `cpu_rd` is high and `cpu_addr` is 0x1E, `cpu_rdata` returns the flags in bits 6..0, with bit i belonging to endpoint i, and 0 in bits 15..7. Any other read returns 0.
- R4: A write to 0x1E clears flag i if `cpu_wdata[i]` is 0 and leaves it unchanged if that bit is 1. Bits 15..7 of the write data are ignored.
- R5: Take an endpoint whose `ep_dir` bit is 0 (OUT) and which is not isochronous. A `rx_end` for that endpoint with `rx_len` strictly greater than its maximum packet size sets its flag. A length equal to the maximum packet size does not.
- R6: Take an endpoint whose `ep_dir` bit is 1 (IN) and which is not isochronous. A `tx_drained` pulse sets its flag only if `cpu_pending` is 0 for that endpoint.
- R7: For endpoints 1..6, a high `ep_iso` bit blocks both setting conditions and the STALL request.
- R8: For endpoint 0, `ep_dir[0]` selects the mode. A value of 0 (control write) uses the size-over condition against `mps_flat[10:0]`. A value of 1 (control read) uses the buffer-empty condition.
- R9: A size-over event raises `stall_req` for that endpoint for exactly one cycle, in the same cycle in which its flag first reads 1.
- R10: Flag 0 clears one cycle after `ep0_ival` falls from 1 to 0.
- R11: Flag 0 clears when `ep0_bclr` is pulsed while `ep0_tx_present` is 1. The pulse has no effect while `ep0_tx_present` is 0.
- R12: If a set event and a clear (by CPU write or by hardware) hit the same flag in the same cycle, the flag ends up set.
- R13: `irq` is 1 exactly when some flag i is 1 and `irq_en[i]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| sw_rst | input | 1 | Synchronous software reset, active high |
| cpu_addr | input | 8 | Register address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, 0 when the register is not selected |
| ep_dir | input | 7 | Per-endpoint direction: 1 = IN / control read, 0 = OUT / control write |
| ep_iso | input | 7 | Per-endpoint isochronous mode (bit 0 unused) |
| mps_flat | input | 77 | Maximum packet size, 11 bits per endpoint, endpoint 0 in the low bits |
| rx_end | input | 1 | Pulse marking the end of a received packet |
| rx_ep | input | 3 | Endpoint number of the received packet |
| rx_len | input | 11 | Length of the received packet in bytes |
| tx_drained | input | 7 | Per-endpoint pulse: serial-engine buffer fully sent |
| cpu_pending | input | 7 | Per-endpoint level: CPU-side buffer holds new data |
| ep0_ival | input | 1 | Endpoint 0 FIFO valid level |
| ep0_bclr | input | 1 | Endpoint 0 buffer-clear write pulse |
| ep0_tx_present | input | 1 | Endpoint 0 buffer holds transmit data |
| irq_en | input | 7 | Per-endpoint interrupt enable |
| irq | output | 1 | Combined interrupt |
| stall_req | output | 7 | Per-endpoint one-cycle STALL request |

## Verification
The internal state consists of the flag vector and the delayed endpoint 0 valid level. A wrong flag appears in `cpu_rdata` and in `irq` in the cycle right after the edge that set or cleared it. It persists there until the next write, because the flags are sticky. A wrong direction or isochronous decode shows up as a flag or STALL pulse on the wrong endpoint one cycle after the event. A stale delayed valid level shows up as a missed or spurious clear of flag 0 one cycle after `ep0_ival` moves.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
    localparam int NUM_EP   = 7;
    localparam int EP_ID_W  = $clog2(NUM_EP);
    localparam int LEN_W    = 11;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 8;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 8'h1E;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } ep_dir_e;

    typedef struct packed {
        logic size_over;
        logic buf_empty;
    } ep_evt_t;

    function automatic logic pkt_oversize(input logic [LEN_W-1:0] len,
                                          input logic [LEN_W-1:0] limit);
        return len > limit;
    endfunction
endpackage

// File: rtl/ep_evt_detect.sv
module ep_evt_detect
    import ep_irq_pkg::*;
#(
    parameter int EP_ID       = 0,
    parameter bit ISO_CAPABLE = 1'b1
) (
    input  logic               dir,
    input  logic               iso,
    input  logic               rx_end,
    input  logic [EP_ID_W-1:0] rx_ep,
    input  logic [LEN_W-1:0]   rx_len,
    input  logic [LEN_W-1:0]   mps,
    input  logic               tx_drained,
    input  logic               cpu_pending,
    output ep_evt_t            evt
);
    logic    blocked;
    logic    rx_hit;
    ep_dir_e mode;

    always_comb begin
        mode          = ep_dir_e'(dir);
        blocked       = ISO_CAPABLE && iso;
        rx_hit        = rx_end && (rx_ep == EP_ID_W'(EP_ID));
        evt.size_over = rx_hit && (mode == DIR_OUT) && !blocked
                        && pkt_oversize(rx_len, mps);
        evt.buf_empty = tx_drained && !cpu_pending && (mode == DIR_IN) && !blocked;
    end
endmodule

// File: rtl/ep_irq_regport.sv
module ep_irq_regport
    import ep_irq_pkg::*;
#(
    parameter int                N_EP = NUM_EP,
    parameter logic [ADDR_W-1:0] ADDR = STATUS_ADDR
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [N_EP-1:0]   flags,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [N_EP-1:0]   wr_clr
);
    logic sel;

    always_comb begin
        sel       = (cpu_addr == ADDR);
        wr_clr    = (cpu_wr && sel) ? ~cpu_wdata[N_EP-1:0] : '0;
        cpu_rdata = (cpu_rd && sel) ? DATA_W'(flags) : '0;
    end
endmodule

// File: rtl/ep_flag_bank.sv
module ep_flag_bank #(
    parameter int N_EP = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_rst,
    input  logic [N_EP-1:0] set_vec,
    input  logic [N_EP-1:0] clr_vec,
    input  logic [N_EP-1:0] stall_vec,
    output logic [N_EP-1:0] flags,
    output logic [N_EP-1:0] stall_q
);
    always_ff @(posedge clk) begin
        if (rst || sw_rst) begin
            flags   <= '0;
            stall_q <= '0;
        end else begin
            flags   <= set_vec | (flags & ~clr_vec);
            stall_q <= stall_vec;
        end
    end
endmodule

// File: rtl/ep_irq_status_reg.sv
module ep_irq_status_reg
    import ep_irq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sw_rst,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic                    cpu_rd,
    input  logic                    cpu_wr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic [DATA_W-1:0]       cpu_rdata,
    input  logic [NUM_EP-1:0]       ep_dir,
    input  logic [NUM_EP-1:0]       ep_iso,
    input  logic [NUM_EP*LEN_W-1:0] mps_flat,
    input  logic                    rx_end,
    input  logic [EP_ID_W-1:0]      rx_ep,
    input  logic [LEN_W-1:0]        rx_len,
    input  logic [NUM_EP-1:0]       tx_drained,
    input  logic [NUM_EP-1:0]       cpu_pending,
    input  logic                    ep0_ival,
    input  logic                    ep0_bclr,
    input  logic                    ep0_tx_present,
    input  logic [NUM_EP-1:0]       irq_en,
    output logic                    irq,
    output logic [NUM_EP-1:0]       stall_req
);
    ep_evt_t [NUM_EP-1:0] evt;
    logic [NUM_EP-1:0] set_vec;
    logic [NUM_EP-1:0] so_vec;
    logic [NUM_EP-1:0] wr_clr;
    logic [NUM_EP-1:0] clr_vec;
    logic [NUM_EP-1:0] flags;
    logic              ival_q;
    logic              ep0_hw_clr;

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        ep_evt_detect #(
            .EP_ID       (i),
            .ISO_CAPABLE (i != 0)
        ) u_det (
            .dir         (ep_dir[i]),
            .iso         (ep_iso[i]),
            .rx_end      (rx_end),
            .rx_ep       (rx_ep),
            .rx_len      (rx_len),
            .mps         (mps_flat[i*LEN_W +: LEN_W]),
            .tx_drained  (tx_drained[i]),
            .cpu_pending (cpu_pending[i]),
            .evt         (evt[i])
        );
        assign so_vec[i]  = evt[i].size_over;
        assign set_vec[i] = evt[i].size_over | evt[i].buf_empty;
    end

    always_ff @(posedge clk) begin
        if (rst) ival_q <= 1'b0;
        else     ival_q <= ep0_ival;
    end

    always_comb begin
        ep0_hw_clr = (ival_q && !ep0_ival) || (ep0_bclr && ep0_tx_present);
        clr_vec    = wr_clr | NUM_EP'(ep0_hw_clr);
    end

    ep_irq_regport u_port (
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .flags     (flags),
        .cpu_rdata (cpu_rdata),
        .wr_clr    (wr_clr)
    );

    ep_flag_bank #(.N_EP(NUM_EP)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .sw_rst    (sw_rst),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .stall_vec (so_vec),
        .flags     (flags),
        .stall_q   (stall_req)
    );

    assign irq = |(flags & irq_en);
endmodule

// File: rtl/ep_irq_status_chk.sv
module ep_irq_status_chk
    import ep_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sw_rst,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              rx_end,
    input logic [NUM_EP-1:0] tx_drained,
    input logic [NUM_EP-1:0] flags,
    input logic [NUM_EP-1:0] stall_req,
    input logic [NUM_EP-1:0] irq_en,
    input logic              irq
);
    assert_hw_reset_R1: assert property (@(posedge clk) rst |=> (flags == '0 && stall_req == '0));

    assert_sw_reset_R2: assert property (@(posedge clk) disable iff (rst) sw_rst |=> flags == '0);

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_rdata[DATA_W-1:NUM_EP] == '0);

    assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (rst)
        (!rx_end && tx_drained == '0) |=> ((flags & ~$past(flags)) == '0));

    assert_stall_single_R9: assert property (@(posedge clk) disable iff (rst) $onehot0(stall_req));

    assert_stall_has_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (stall_req & ~flags) == '0);

    assert_irq_masked_R13: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq);
endmodule

bind ep_irq_status_reg ep_irq_status_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sw_rst     (sw_rst),
    .cpu_rdata  (cpu_rdata),
    .rx_end     (rx_end),
    .tx_drained (tx_drained),
    .flags      (flags),
    .stall_req  (stall_req),
    .irq_en     (irq_en),
    .irq        (irq)
);

// File: tb/ep_irq_status_reg_test.sv
module ep_irq_status_reg_test;
    logic        clk = 1'b0;
    logic        rst, sw_rst;
    logic [7:0]  cpu_addr;
    logic        cpu_rd, cpu_wr;
    logic [15:0] cpu_wdata, cpu_rdata;
    logic [6:0]  ep_dir, ep_iso, tx_drained, cpu_pending, irq_en, stall_req;
    logic [76:0] mps_flat;
    logic [10:0] mps [7];
    logic        rx_end;
    logic [2:0]  rx_ep;
    logic [10:0] rx_len;
    logic        ep0_ival, ep0_bclr, ep0_tx_present, irq;

    logic [6:0]  exp_flags = '0;
    logic [6:0]  exp_stall = '0;
    logic        exp_prev  = 1'b0;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    always_comb for (int i = 0; i < 7; i++) mps_flat[i*11 +: 11] = mps[i];

    ep_irq_status_reg uut (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ep_dir(ep_dir),
        .ep_iso(ep_iso), .mps_flat(mps_flat), .rx_end(rx_end), .rx_ep(rx_ep),
        .rx_len(rx_len), .tx_drained(tx_drained), .cpu_pending(cpu_pending),
        .ep0_ival(ep0_ival), .ep0_bclr(ep0_bclr), .ep0_tx_present(ep0_tx_present),
        .irq_en(irq_en), .irq(irq), .stall_req(stall_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: model computed from the requirements, outputs sampled after the edge.
    task automatic cyc(input string tag);
        logic [6:0] so, emp, clr;
        logic [15:0] exp_rd;
        for (int i = 0; i < 7; i++) begin
            logic blk;
            blk    = (i > 0) && ep_iso[i];
            so[i]  = rx_end && rx_ep == 3'(i) && !ep_dir[i] && !blk && rx_len > mps[i];
            emp[i] = tx_drained[i] && !cpu_pending[i] && ep_dir[i] && !blk;
        end
        clr = (cpu_wr && cpu_addr == 8'h1E) ? ~cpu_wdata[6:0] : 7'h0;
        clr[0] = clr[0] | (exp_prev && !ep0_ival) | (ep0_bclr && ep0_tx_present);
        @(posedge clk);
        if (rst || sw_rst) begin
            exp_flags = '0;
            exp_stall = '0;
        end else begin
            exp_flags = so | emp | (exp_flags & ~clr);
            exp_stall = so;
        end
        exp_prev = rst ? 1'b0 : ep0_ival;
        #1;
        exp_rd = (cpu_rd && cpu_addr == 8'h1E) ? {9'h0, exp_flags} : 16'h0;
        chk({tag, " rdata"}, 32'(cpu_rdata), 32'(exp_rd));
        chk({tag, " R9 stall"}, 32'(stall_req), 32'(exp_stall));
        chk({tag, " R13 irq"}, 32'(irq), 32'(|(exp_flags & irq_en)));
        @(negedge clk);
        rst = 0; sw_rst = 0; rx_end = 0; tx_drained = '0; ep0_bclr = 0; cpu_wr = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1; sw_rst = 0; cpu_addr = 8'h1E; cpu_rd = 1; cpu_wr = 0; cpu_wdata = '0;
        ep_dir = '0; ep_iso = '0; tx_drained = '0; cpu_pending = '0; irq_en = 7'h7F;
        rx_end = 0; rx_ep = '0; rx_len = '0; ep0_ival = 0; ep0_bclr = 0; ep0_tx_present = 0;
        for (int i = 0; i < 7; i++) mps[i] = 11'd16;
        @(negedge clk);
        rst = 1; cyc("R1 reset");
        rst = 1; cyc("R1 reset hold");

        // R5 boundary and oversize, R9 pulse width
        rx_end = 1; rx_ep = 3; rx_len = 16; cyc("R5 equal length");
        rx_end = 1; rx_ep = 3; rx_len = 17; cyc("R5 oversize");
        cyc("R9 pulse one cycle");
        // R4 write semantics
        cpu_wr = 1; cpu_wdata = 16'h007F; cyc("R4 write ones");
        cpu_wr = 1; cpu_wdata = 16'hFFF7; cyc("R4 write zero");
        // R3 other address and reserved bits
        rx_end = 1; rx_ep = 1; rx_len = 40; cyc("R3 set for read");
        cpu_addr = 8'h1C; cyc("R3 other address");
        cpu_addr = 8'h1E; cpu_rd = 0; cyc("R3 no strobe");
        cpu_rd = 1; cpu_wr = 1; cpu_addr = 8'h1C; cpu_wdata = 16'h0; cyc("R4 write elsewhere");
        cpu_addr = 8'h1E;
        // R6 buffer empty
        ep_dir[2] = 1; tx_drained[2] = 1; cpu_pending[2] = 1; cyc("R6 pending data");
        cpu_pending[2] = 0; tx_drained[2] = 1; cyc("R6 empty");
        // R7 isochronous
        ep_iso[4] = 1; ep_dir[4] = 1; tx_drained[4] = 1; cyc("R7 iso in");
        ep_dir[4] = 0; rx_end = 1; rx_ep = 4; rx_len = 60; cyc("R7 iso out");
        // R8 endpoint 0 modes
        mps[0] = 8; ep_dir[0] = 0; rx_end = 1; rx_ep = 0; rx_len = 9; cyc("R8 control write");
        cpu_wr = 1; cpu_wdata = 16'hFFFE; cyc("R4 clear ep0");
        ep_dir[0] = 1; rx_end = 1; rx_ep = 0; rx_len = 9; cyc("R8 control read rx");
        tx_drained[0] = 1; cyc("R8 control read empty");
        // R10 valid fall
        ep0_ival = 1; cyc("R10 valid high");
        ep0_ival = 0; cyc("R10 valid fall");
        // R11 buffer clear
        tx_drained[0] = 1; cyc("R11 set ep0");
        ep0_bclr = 1; ep0_tx_present = 0; cyc("R11 no tx data");
        ep0_bclr = 1; ep0_tx_present = 1; cyc("R11 tx data");
        ep0_tx_present = 0;
        // R12 set beats clear
        ep_dir[5] = 0; rx_end = 1; rx_ep = 5; rx_len = 30;
        cpu_wr = 1; cpu_wdata = 16'h0; cyc("R12 set wins");
        tx_drained[0] = 1; cyc("R12 set ep0");
        ep0_ival = 1; cyc("R12 prep");
        ep0_ival = 0; tx_drained[0] = 1; cyc("R12 hw clear vs set");
        // R13 enable masking
        irq_en = '0; cyc("R13 masked");
        irq_en = 7'h20; cyc("R13 enabled");
        irq_en = 7'h02; cyc("R13 other bit");
        // R2 soft reset
        sw_rst = 1; cyc("R2 soft reset");
        irq_en = 7'h7F;

        // Random phases
        for (int ph = 0; ph < 20; ph++) begin
            ep_dir = 7'($urandom);
            ep_iso = 7'($urandom) & 7'($urandom);
            for (int i = 0; i < 7; i++) mps[i] = 11'(8 + $urandom_range(0, 24));
            for (int n = 0; n < 150; n++) begin
                rx_end = ($urandom_range(0, 9) < 3);
                rx_ep = 3'($urandom_range(0, 6));
                rx_len = 11'($urandom_range(0, 40));
                tx_drained = 7'($urandom) & 7'($urandom);
                cpu_pending = 7'($urandom);
                ep0_ival = ($urandom_range(0, 3) == 0) ? ~ep0_ival : ep0_ival;
                ep0_bclr = ($urandom_range(0, 19) == 0);
                ep0_tx_present = 1'($urandom);
                cpu_wr = ($urandom_range(0, 6) == 0);
                cpu_wdata = 16'($urandom);
                cpu_addr = ($urandom_range(0, 9) == 0) ? 8'h1C : 8'h1E;
                cpu_rd = ($urandom_range(0, 7) != 0);
                irq_en = 7'($urandom);
                sw_rst = ($urandom_range(0, 199) == 0);
                cyc("R5 R6 R8 R10 R11 R12 random");
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule